// File: doc/BRIEF.md
# Multichannel DAC Code Update Engine

This block holds the output codes of sixteen converter channels and applies write commands to them. Each command has a 2-bit mode, a 4-bit channel address and a 12-bit payload. A command can load a new 12-bit code into a channel. It can move the channel up or down in quarter-LSB steps. It can also do nothing. Each channel keeps a 14-bit fine value: the 12-bit code followed by two sub-LSB bits.

Commands arrive on a valid/ready stream. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. A sender that sees `cmd_ready` low must hold its command, because nothing is queued. After a load or a step, the active-low `busy_n` output stays low for a settling interval, and `cmd_ready` stays low with it. The load interval is long and the step interval is short; both are parameters given in clock cycles. A combinational readback port returns the fine value of any channel.

Top module: `dac_code_engine`

## Requirements
- R1: While `rst_n` is low and after it rises, every channel reads 14'h2000 (midscale), `busy_n` is high, and once `rst_n` is high `cmd_ready` is high.
- R2: An accepted command with mode 2'b00 sets the addressed channel to `{cmd_data[11:0], 2'b00}`.
- R3: An accepted command with mode 2'b01 raises the addressed channel by `cmd_data[6:0]` quarter-LSB units. Bits `cmd_data[11:7]` have no effect.
- R4: An accepted command with mode 2'b10 lowers the addressed channel by `cmd_data[6:0]` quarter-LSB units.
- R5: An increment saturates at 16383 and a decrement saturates at 0. Neither wraps.
- R6: An accepted command with mode 2'b11 changes no channel and leaves `busy_n` high.
- R7: A mode 2'b01 or 2'b10 command with `cmd_data[6:0]` equal to zero changes no channel but still produces the short busy interval.
- R8: After the accepting edge, `busy_n` is low for exactly LOAD_CYCLES cycles for a mode 2'b00 command and STEP_CYCLES cycles for a mode 2'b01 or 2'b10 command.
- R9: While `busy_n` is low, `cmd_ready` is low, and a command offered on `cmd_valid` is not taken and has no effect.
- R10: Only the channel selected by `cmd_addr`, with bit 3 as the most significant bit, changes.
- R11: `rd_code` shows the fine value of channel `rd_addr` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_mode | input | 2 | 00 load, 01 increment, 10 decrement, 11 no-op |
| cmd_addr | input | 4 | Channel select |
| cmd_data | input | 12 | Load code, or step count in bits 6..0 |
| busy_n | output | 1 | Low while an update settles |
| rd_addr | input | 4 | Readback channel select |
| rd_code | output | 14 | Fine value of the selected channel |

## Verification
The assertions check four things on every cycle. A load or step pulls `busy_n` low on the next cycle. A no-op leaves `busy_n` high. No low run of `busy_n` is longer than the load interval. A write changes only its target channel, and a load stores the shifted payload. Some behaviour needs known history, so only the bench scenarios can show it: the saturation end points, the exact length of each busy interval, and the case where a command is held during busy and never takes effect. The bench also compares every channel against a reference model.

// File: rtl/dac_eng_pkg.sv
package dac_eng_pkg;
  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_INC  = 2'b01,
    MODE_DEC  = 2'b10,
    MODE_NOP  = 2'b11
  } mode_e;

  typedef struct packed {
    logic is_load;
    logic is_step;
    logic step_up;
  } cmd_kind_t;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_eng_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int STEP_W = 7
) (
  input  logic [1:0]        mode,
  input  logic [CODE_W-1:0] data,
  output cmd_kind_t         kind,
  output logic [STEP_W-1:0] step,
  output logic              step_zero
);
  always_comb begin
    kind = '0;
    unique case (mode_e'(mode))
      MODE_LOAD: kind.is_load = 1'b1;
      MODE_INC:  begin kind.is_step = 1'b1; kind.step_up = 1'b1; end
      MODE_DEC:  kind.is_step = 1'b1;
      default:   kind = '0;
    endcase
  end

  assign step      = data[STEP_W-1:0];
  assign step_zero = (step == '0);
endmodule

// File: rtl/dac_fine_step.sv
module dac_fine_step #(
  parameter int FINE_W = 14,
  parameter int STEP_W = 7
) (
  input  logic [FINE_W-1:0] cur,
  input  logic [STEP_W-1:0] step,
  input  logic              up,
  output logic [FINE_W-1:0] nxt
);
  localparam logic [FINE_W-1:0] TOP = '1;
  logic [FINE_W:0] sum;
  logic [FINE_W:0] stp_ext;

  always_comb begin
    stp_ext = {{(FINE_W+1-STEP_W){1'b0}}, step};
    sum     = {1'b0, cur} + stp_ext;
    if (up) begin
      nxt = sum[FINE_W] ? TOP : sum[FINE_W-1:0];
    end else begin
      nxt = ({1'b0, cur} < stp_ext) ? '0 : cur - stp_ext[FINE_W-1:0];
    end
  end
endmodule

// File: rtl/dac_busy_timer.sv
module dac_busy_timer #(
  parameter int LOAD_CYCLES = 1250,
  parameter int STEP_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_long,
  input  logic start_short,
  output logic busy_n
);
  localparam int CW = $clog2(LOAD_CYCLES + 1);
  localparam logic [CW-1:0] LONG_V  = CW'(LOAD_CYCLES);
  localparam logic [CW-1:0] SHORT_V = CW'(STEP_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start_long)  cnt <= LONG_V;
    else if (start_short) cnt <= SHORT_V;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy_n = (cnt == '0);

  // Run-length checker: a low run must never exceed the long interval
  logic [CW:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_run <= '0;
    else if (!busy_n) low_run <= low_run + 1'b1;
    else              low_run <= '0;
  end

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= (CW+1)'(LOAD_CYCLES)) else $error("busy run too long"); // R8
  AST_START_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_long || start_short) |=> !busy_n) else $error("busy not raised"); // R8
endmodule

// File: rtl/dac_channel_bank.sv
module dac_channel_bank #(
  parameter int NCH    = 16,
  parameter int FINE_W = 14,
  parameter logic [FINE_W-1:0] RST_VAL = 14'h2000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [$clog2(NCH)-1:0] wr_addr,
  input  logic [FINE_W-1:0]      wr_val,
  output logic [FINE_W-1:0]      cur_val,
  input  logic [$clog2(NCH)-1:0] rd_addr,
  output logic [FINE_W-1:0]      rd_val
);
  logic [FINE_W-1:0] q [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q[i] <= RST_VAL;
      else if (we && (int'(wr_addr) == i))  q[i] <= wr_val;
    end

    AST_OTHERS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (int'(wr_addr) == i)) |=> $stable(q[i])) else $error("stray write"); // R10
  end

  assign cur_val = q[wr_addr];
  assign rd_val  = q[rd_addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q[$past(wr_addr)] == $past(wr_val))) else $error("write lost"); // R2
endmodule

// File: rtl/dac_code_engine.sv
module dac_code_engine
  import dac_eng_pkg::*;
#(
  parameter int NCH         = 16,
  parameter int CODE_W      = 12,
  parameter int FRAC_W      = 2,
  parameter int STEP_W      = 7,
  parameter int LOAD_CYCLES = 1250,
  parameter int STEP_CYCLES = 50
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [1:0]             cmd_mode,
  input  logic [$clog2(NCH)-1:0] cmd_addr,
  input  logic [CODE_W-1:0]      cmd_data,
  output logic                   busy_n,
  input  logic [$clog2(NCH)-1:0] rd_addr,
  output logic [CODE_W+FRAC_W-1:0] rd_code
);
  localparam int FINE_W = CODE_W + FRAC_W;
  localparam logic [FINE_W-1:0] MID = FINE_W'(1) << (FINE_W - 1);

  cmd_kind_t         kind;
  logic [STEP_W-1:0] step;
  logic              step_zero;
  logic [FINE_W-1:0] cur_val, stepped, wr_val;
  logic              accept, we;

  dac_cmd_decode #(.CODE_W(CODE_W), .STEP_W(STEP_W)) u_dec (
    .mode(cmd_mode), .data(cmd_data), .kind(kind), .step(step), .step_zero(step_zero)
  );

  dac_fine_step #(.FINE_W(FINE_W), .STEP_W(STEP_W)) u_step (
    .cur(cur_val), .step(step), .up(kind.step_up), .nxt(stepped)
  );

  assign cmd_ready = busy_n && rst_n;
  assign accept    = cmd_valid && cmd_ready;
  assign we        = accept && (kind.is_load || (kind.is_step && !step_zero));
  assign wr_val    = kind.is_load ? {cmd_data, {FRAC_W{1'b0}}} : stepped;

  dac_channel_bank #(.NCH(NCH), .FINE_W(FINE_W), .RST_VAL(MID)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .wr_addr(cmd_addr), .wr_val(wr_val),
    .cur_val(cur_val), .rd_addr(rd_addr), .rd_val(rd_code)
  );

  dac_busy_timer #(.LOAD_CYCLES(LOAD_CYCLES), .STEP_CYCLES(STEP_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .start_long(accept && kind.is_load),
    .start_short(accept && kind.is_step),
    .busy_n(busy_n)
  );

  AST_NOP_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_mode == 2'b11) |=> busy_n) else $error("nop busy"); // R6
  AST_LOAD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_mode == 2'b00) |=> (!busy_n && !cmd_ready)) else $error("load not busy"); // R9
endmodule

// File: tb/sim_dac_code_engine.sv
`timescale 1ns/1ps
module sim_dac_code_engine;
  localparam int LOADC = 1250;
  localparam int STEPC = 50;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready, busy_n;
  logic [1:0] cmd_mode = 0;
  logic [3:0] cmd_addr = 0, rd_addr = 0;
  logic [11:0] cmd_data = 0;
  logic [13:0] rd_code;
  int errors = 0, checks = 0;
  int model [16];

  always #10 clk = ~clk;

  dac_code_engine #(.LOAD_CYCLES(LOADC), .STEP_CYCLES(STEPC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .busy_n(busy_n), .rd_addr(rd_addr), .rd_code(rd_code));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_addr = 4'(a); #1; v = int'(rd_code);
  endtask

  function automatic void apply(input int m, input int a, input int d);
    int s = d & 127;
    if (m == 0) model[a] = (d & 4095) << 2;
    else if (m == 1) model[a] = (model[a] + s > 16383) ? 16383 : model[a] + s;
    else if (m == 2) model[a] = (model[a] < s) ? 0 : model[a] - s;
  endfunction

  task automatic send(input int m, input int a, input int d, output int bc);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_mode = 2'(m); cmd_addr = 4'(a); cmd_data = 12'(d); cmd_valid = 1;
    @(posedge clk); #1 cmd_valid = 0;
    apply(m, a, d);
    bc = 0;
    @(negedge clk);
    while (!busy_n) begin bc++; @(negedge clk); end
  endtask

  task automatic check_all(input string tag);
    int v;
    for (int i = 0; i < 16; i++) begin
      rd(i, v); chk(tag, v, model[i]);
    end
  endtask

  task automatic t_reset;
    int v;
    for (int i = 0; i < 16; i++) model[i] = 14'h2000;
    rd(3, v); chk("R1 midscale in reset", v, 14'h2000);
    chk("R1 busy_n in reset", int'(busy_n), 1);
    @(negedge clk); rst_n = 1;
    @(negedge clk); chk("R1 ready after reset", int'(cmd_ready), 1);
    check_all("R1 all channels midscale");
  endtask

  task automatic t_load;
    int bc, v;
    send(0, 4'b1000, 12'hABC, bc);
    chk("R8 load busy length", bc, LOADC);
    rd(8, v); chk("R2 load shifted payload", v, 12'hABC << 2);
    rd(0, v); chk("R10 A3 is msb, ch0 untouched", v, 14'h2000);
    send(0, 15, 12'hFFF, bc);
    rd(15, v); chk("R2 load full scale", v, 16380);
  endtask

  task automatic t_inc_dec;
    int bc, v;
    send(1, 8, 12'hF85, bc);   // upper bits set, step 5
    chk("R8 step busy length", bc, STEPC);
    rd(8, v); chk("R3 increment ignores upper bits", v, (12'hABC << 2) + 5);
    send(2, 8, 127, bc);
    chk("R8 dec busy length", bc, STEPC);
    rd(8, v); chk("R4 decrement by 127", v, (12'hABC << 2) + 5 - 127);
  endtask

  task automatic t_sat;
    int bc, v;
    send(1, 15, 100, bc);
    rd(15, v); chk("R5 increment saturates at 16383", v, 16383);
    send(0, 2, 0, bc);
    send(2, 2, 3, bc);
    rd(2, v); chk("R5 decrement saturates at 0", v, 0);
    send(0, 2, 1, bc);
    send(2, 2, 4, bc);
    rd(2, v); chk("R5 decrement to exactly 0", v, 0);
  endtask

  task automatic t_nop_zero;
    int bc, v;
    send(3, 8, 12'hFFF, bc);
    chk("R6 nop no busy", bc, 0);
    send(1, 8, 12'h080, bc);   // step field zero
    chk("R7 zero step short busy", bc, STEPC);
    send(2, 8, 0, bc);
    chk("R7 zero dec short busy", bc, STEPC);
    check_all("R6 R7 no channel changed");
  endtask

  task automatic t_busy_ignore;
    int bc, v;
    send(0, 5, 12'h123, bc);
    @(negedge clk); cmd_mode = 2'b00; cmd_addr = 4'd5; cmd_data = 12'h3A0; cmd_valid = 1;
    @(posedge clk); #1 cmd_valid = 0;
    apply(0, 5, 12'h3A0);
    @(negedge clk);
    chk("R9 busy_n low after load", int'(busy_n), 0);
    cmd_mode = 2'b01; cmd_addr = 4'd5; cmd_data = 12'd50; cmd_valid = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk("R9 ready low while busy", int'(cmd_ready), 0);
    end
    cmd_valid = 0;
    while (!busy_n) @(negedge clk);
    rd(5, v); chk("R9 held command not taken", v, 12'h3A0 << 2);
  endtask

  task automatic t_readback;
    int v;
    @(negedge clk); rd_addr = 4'd8; #1;
    chk("R11 readback ch8", int'(rd_code), model[8]);
    rd_addr = 4'd15; #1;
    chk("R11 readback same cycle", int'(rd_code), model[15]);
    check_all("R10 final sweep");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_load;
    t_inc_dec;
    t_sat;
    t_nop_zero;
    t_busy_ignore;
    t_readback;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule